// File: doc/BRIEF.md
# Cascaded Two-Controller Interrupt Acknowledge Unit

This block joins two eight-input priority interrupt controllers into one sixteen-line system. System line `n` is handled by controller `n >> 3` on input `n & 7`, so lines 0 to 7 reach the master and lines 8 to 15 reach the slave. The slave does not drive the processor itself. Whenever the slave has a request that would win, the master's cascade input (input 2) is pulsed, and the master latches it as an edge request. The master's "would interrupt" flag is the processor interrupt output.

On a processor acknowledge the block resolves the master first. If the master's winner is the cascade input, the slave is resolved and acknowledged too, and the vector comes from the slave's base. If a controller has nothing to offer at that moment, it answers with its spurious line 7. Each controller has a per-line trigger-select register. It picks level or edge sensing, and only some bits can be written. A controller initialise command leaves this register untouched. Only the block's reset clears it. Software reaches the register state through a small select/data write port and a combinational read port. The same port carries the end-of-interrupt commands.

Top module: `pic_cascade`

## Requirements
- R1: System line n sets pending bit (n AND 7) of controller n >> 3 (0 = master, 1 = slave). A master winner k yields vector master_base + k. A slave winner j yields slave_base + j. A base write keeps only bits 7..3 of the data.
- R2: While the slave has a winning request and no acknowledge is in progress, master pending bit 2 is set on the next clock edge.
- R3: On acknowledge with a master winner k, master in-service bit k is set. If k = 2 and the slave has a winner j, slave in-service bit j is also set and the vector is slave_base + j.
- R4: If the master's winner is 2 but the slave has no winner, the vector is slave_base + 7.
- R5: If the master has no winner, the vector is master_base + 7 and no in-service bit changes.
- R6: Trigger-select writes keep only the bits under mask 0xF8 for the master and 0xDE for the slave.
- R7: The controller initialise command (command data bit 0) clears pending, in-service, mask, base and rotation of that controller but not its trigger-select register. rst_n clears everything.
- R8: A line whose trigger bit is 1 is level-sensed: its pending bit follows the input and survives acknowledge. A line whose trigger bit is 0 is edge-sensed: a rising input sets the pending bit and acknowledge clears it.
- R9: Priority order starts at the rotation origin (0 after reset), with lower offsets winning. A masked line never wins. A pending line wins only if it ranks above every in-service line.
- R10: Command data bit 1 clears the highest-ranked in-service bit i. Command data bit 2 does the same and also moves the rotation origin to i + 1.
- R11: int_out is high exactly when the master has a winner, evaluated combinationally from current state.
- R12: vec_valid is high in the cycle after each acknowledge and at no other time. vector holds the value resolved at that acknowledge.

Write port select `wr_sel`: bit 0 picks the controller. Bits 2..1 select the target: 0 = mask, 1 = base, 2 = trigger-select, 3 = command. Read port select `rd_sel`: bit 0 picks the controller. Bits 2..1 select what is read: 0 = pending, 1 = in-service, 2 = mask, 3 = trigger-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all state including trigger-select |
| irq_in | input | 16 | System interrupt lines |
| ack | input | 1 | Processor acknowledge, one cycle per acknowledge |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Read source select |
| rd_data | output | 8 | Combinational read data |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after ack |
| vector | output | 8 | Acknowledged vector |

## Verification
The bound checker watches several rules on every cycle:
- the one-cycle relation between an acknowledge and vec_valid;
- the spurious-master answer, which leaves in-service untouched;
- the cascade latch into master bit 2 while the slave is requesting;
- the growth of master in-service on a real acknowledge;
- trigger-select write masking;
- the rule that int_out only rises when an unmasked master request exists.

Only the bench scenarios can show the full vector values and the rest of the priority behaviour. These include slave-spurious resolution after the slave is masked late, survival of level requests across an acknowledge, rotation changing which line wins, and trigger-select persisting across the initialise command but not across reset.

// File: rtl/pic_cascade.sv
module pic_cascade #(
  parameter logic [7:0] MASTER_TRIG_MASK = 8'hF8,
  parameter logic [7:0] SLAVE_TRIG_MASK  = 8'hDE,
  parameter int         CASCADE_LINE     = 2,
  parameter logic [2:0] SPURIOUS_LINE    = 3'd7
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic        ack,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  rd_sel,
  output logic [7:0]  rd_data,
  output logic        int_out,
  output logic        vec_valid,
  output logic [7:0]  vector
);
  localparam int NL = 8;
  localparam int NC = 2;
  localparam logic [2:0] CASC = 3'(CASCADE_LINE);

  function automatic logic [3:0] rank(input logic [7:0] m, input logic [2:0] org);
    logic [3:0] r;
    r = 4'd8;
    for (int p = NL - 1; p >= 0; p--)
      if (m[3'(p) + org]) r = 4'(p);
    return r;
  endfunction

  function automatic logic [3:0] pick(input logic [7:0] pend, input logic [7:0] msk,
                                      input logic [7:0] svc, input logic [2:0] org);
    logic [3:0] p, c;
    p = rank(pend & ~msk, org);
    c = rank(svc, org);
    if (p < c) return {1'b0, p[2:0] + org};
    return 4'd8;
  endfunction

  logic [7:0] irr_q [NC], irr_d [NC];
  logic [7:0] isr_q [NC], isr_d [NC];
  logic [7:0] imr_q [NC], imr_d [NC];
  logic [7:0] base_q[NC], base_d[NC];
  logic [7:0] trig_q[NC], trig_d[NC];
  logic [7:0] last_q[NC], last_d[NC];
  logic [2:0] org_q [NC], org_d [NC];
  logic [3:0] m_win, s_win;
  logic       s_pend;
  logic [7:0] vec_d;

  assign m_win   = pick(irr_q[0], imr_q[0], isr_q[0], org_q[0]);
  assign s_win   = pick(irr_q[1], imr_q[1], isr_q[1], org_q[1]);
  assign s_pend  = !s_win[3];
  assign int_out = !m_win[3];

  logic [7:0] m_irr, m_imr, m_isr, m_trig;
  assign m_irr  = irr_q[0];
  assign m_imr  = imr_q[0];
  assign m_isr  = isr_q[0];
  assign m_trig = trig_q[0];

  always_comb begin
    if (m_win[3])
      vec_d = base_q[0] + 8'(SPURIOUS_LINE);
    else if (m_win[2:0] == CASC)
      vec_d = s_win[3] ? base_q[1] + 8'(SPURIOUS_LINE) : base_q[1] + 8'(s_win[2:0]);
    else
      vec_d = base_q[0] + 8'(m_win[2:0]);
  end

  always_comb begin
    logic [3:0] er;
    logic [2:0] ei;
    logic       lvl;
    er = 4'd8;
    ei = 3'd0;
    for (int c = 0; c < NC; c++) begin
      irr_d[c]  = irr_q[c];
      isr_d[c]  = isr_q[c];
      imr_d[c]  = imr_q[c];
      base_d[c] = base_q[c];
      trig_d[c] = trig_q[c];
      last_d[c] = last_q[c];
      org_d[c]  = org_q[c];
      for (int b = 0; b < NL; b++) begin
        lvl = irq_in[c*NL + b];
        if (trig_q[c][b]) begin
          irr_d[c][b]  = lvl;
          last_d[c][b] = lvl;
        end else begin
          if (lvl && !last_q[c][b]) irr_d[c][b] = 1'b1;
          last_d[c][b] = lvl;
        end
      end
    end
    if (!ack && s_pend) begin
      irr_d[0][CASC]  = 1'b1;
      last_d[0][CASC] = 1'b0;
    end
    if (ack && !m_win[3]) begin
      isr_d[0][m_win[2:0]] = 1'b1;
      if (!trig_q[0][m_win[2:0]]) irr_d[0][m_win[2:0]] = 1'b0;
      if (m_win[2:0] == CASC && s_pend) begin
        isr_d[1][s_win[2:0]] = 1'b1;
        if (!trig_q[1][s_win[2:0]]) irr_d[1][s_win[2:0]] = 1'b0;
      end
    end
    if (wr_en) begin
      case (wr_sel[2:1])
        2'd0: imr_d[wr_sel[0]]  = wr_data;
        2'd1: base_d[wr_sel[0]] = {wr_data[7:3], 3'b000};
        2'd2: trig_d[wr_sel[0]] = wr_data & (wr_sel[0] ? SLAVE_TRIG_MASK : MASTER_TRIG_MASK);
        default: begin
          if (wr_data[0]) begin
            irr_d[wr_sel[0]]  = 8'h00;
            isr_d[wr_sel[0]]  = 8'h00;
            imr_d[wr_sel[0]]  = 8'h00;
            base_d[wr_sel[0]] = 8'h00;
            last_d[wr_sel[0]] = 8'h00;
            org_d[wr_sel[0]]  = 3'd0;
          end else if (wr_data[1] || wr_data[2]) begin
            er = rank(isr_q[wr_sel[0]], org_q[wr_sel[0]]);
            if (!er[3]) begin
              ei = er[2:0] + org_q[wr_sel[0]];
              isr_d[wr_sel[0]][ei] = 1'b0;
              if (wr_data[2]) org_d[wr_sel[0]] = ei + 3'd1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        irr_q[c]  <= '0;
        isr_q[c]  <= '0;
        imr_q[c]  <= '0;
        base_q[c] <= '0;
        trig_q[c] <= '0;
        last_q[c] <= '0;
        org_q[c]  <= '0;
      end
      vec_valid <= 1'b0;
      vector    <= '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        irr_q[c]  <= irr_d[c];
        isr_q[c]  <= isr_d[c];
        imr_q[c]  <= imr_d[c];
        base_q[c] <= base_d[c];
        trig_q[c] <= trig_d[c];
        last_q[c] <= last_d[c];
        org_q[c]  <= org_d[c];
      end
      vec_valid <= ack;
      if (ack) vector <= vec_d;
    end
  end

  always_comb begin
    case (rd_sel[2:1])
      2'd0:    rd_data = irr_q[rd_sel[0]];
      2'd1:    rd_data = isr_q[rd_sel[0]];
      2'd2:    rd_data = imr_q[rd_sel[0]];
      default: rd_data = trig_q[rd_sel[0]];
    endcase
  end
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       int_out,
  input logic       vec_valid,
  input logic [7:0] vector,
  input logic [7:0] m_irr,
  input logic [7:0] m_imr,
  input logic [7:0] m_isr,
  input logic [7:0] m_trig,
  input logic       s_pend
);
  // R12
  vld_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> vec_valid);
  // R12
  vld_only_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) !ack |=> !vec_valid);
  // R5
  spur_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_out && !wr_en) |=> (vector[2:0] == 3'd7) && $stable(m_isr));
  // R2
  cascade_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && s_pend && !(wr_en && wr_sel == 3'b110)) |=> m_irr[2]);
  // R3
  ack_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !wr_en) |=> $countones(m_isr) == $countones($past(m_isr)) + 1);
  // R6
  trig_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'b100) |=> m_trig == ($past(wr_data) & 8'hF8));
  // R11
  int_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (m_irr & ~m_imr) != 8'h00);
endmodule

bind pic_cascade pic_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .int_out(int_out), .vec_valid(vec_valid), .vector(vector),
  .m_irr(m_irr), .m_imr(m_imr), .m_isr(m_isr), .m_trig(m_trig), .s_pend(s_pend)
);

// File: tb/pic_cascade_tb.sv
module pic_cascade_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0, rst_n = 0, ack = 0, wr_en = 0;
  logic [15:0] irq_in = '0;
  logic [2:0]  wr_sel = '0, rd_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data, vector;
  logic        int_out, vec_valid;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  pic_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .int_out(int_out), .vec_valid(vec_valid), .vector(vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    wr_sel = s; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input logic [2:0] s, input logic [7:0] exp, input string tag);
    rd_sel = s;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic ack_exp(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    ack = 1;
    @(negedge clk);
    ack = 0;
    #1;
    chk({"R12 ", tag}, {7'b0, vec_valid}, 8'h01);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL R12: actual unexpected vector %h expected none", vector);
      end else begin
        chk(tag_q.pop_front(), vector, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    chk("reset int_out R11", {7'b0, int_out}, 8'h00);
    chk("reset vec_valid R12", {7'b0, vec_valid}, 8'h00);
    rd_chk(3'b000, 8'h00, "reset master pending");
    rd_chk(3'b111, 8'h00, "reset slave trigger");

    // R6 trigger masks, R7 persistence
    wr(3'b100, 8'hFF);
    wr(3'b101, 8'hFF);
    rd_chk(3'b110, 8'hF8, "R6 master trigger mask");
    rd_chk(3'b111, 8'hDE, "R6 slave trigger mask");
    wr(3'b110, 8'h01);
    wr(3'b111, 8'h01);
    rd_chk(3'b110, 8'hF8, "R7 master trigger kept on init");
    rd_chk(3'b111, 8'hDE, "R7 slave trigger kept on init");
    rst_n = 0; step(1); rst_n = 1; step(1);
    rd_chk(3'b110, 8'h00, "R7 master trigger cleared by reset");
    rd_chk(3'b111, 8'h00, "R7 slave trigger cleared by reset");

    wr(3'b010, 8'h27);
    wr(3'b011, 8'h70);

    // R1 R9 R5 R10
    irq_in[3] = 1; irq_in[5] = 1;
    step(2);
    rd_chk(3'b000, 8'h28, "R1 master pending lines 3,5");
    chk("R11 int_out high", {7'b0, int_out}, 8'h01);
    ack_exp(8'h23, "R9 line 3 beats line 5");
    rd_chk(3'b010, 8'h08, "R3 master in-service line 3");
    chk("R9 in-service blocks lower", {7'b0, int_out}, 8'h00);
    ack_exp(8'h27, "R5 master spurious");
    rd_chk(3'b010, 8'h08, "R5 in-service unchanged");
    wr(3'b110, 8'h02);
    rd_chk(3'b010, 8'h00, "R10 eoi clears line 3");
    ack_exp(8'h25, "R1 master line 5 vector");
    wr(3'b110, 8'h02);
    irq_in[3] = 0; irq_in[5] = 0;
    wr(3'b000, 8'h10);
    irq_in[4] = 1;
    step(2);
    chk("R9 masked line no int", {7'b0, int_out}, 8'h00);
    wr(3'b000, 8'h00);
    ack_exp(8'h24, "R9 unmasked line 4");
    wr(3'b110, 8'h02);
    irq_in[4] = 0;

    // R2 R3 cascade
    irq_in[12] = 1;
    step(3);
    rd_chk(3'b001, 8'h10, "R1 line 12 slave pending bit 4");
    rd_chk(3'b000, 8'h04, "R2 master cascade bit");
    ack_exp(8'h74, "R3 slave vector line 12");
    rd_chk(3'b010, 8'h04, "R3 master in-service bit 2");
    rd_chk(3'b011, 8'h10, "R3 slave in-service bit 4");
    wr(3'b111, 8'h02);
    wr(3'b110, 8'h02);
    irq_in[12] = 0;

    // R4 slave spurious
    irq_in[9] = 1;
    step(3);
    wr(3'b001, 8'h02);
    step(1);
    ack_exp(8'h77, "R4 slave spurious");
    rd_chk(3'b010, 8'h04, "R4 master in-service bit 2");
    wr(3'b110, 8'h02);
    wr(3'b001, 8'h00);
    step(3);
    ack_exp(8'h71, "R3 slave line 9 after unmask");
    wr(3'b111, 8'h02);
    wr(3'b110, 8'h02);
    irq_in[9] = 0;

    // R8 level vs edge
    wr(3'b100, 8'h08);
    irq_in[3] = 1;
    step(2);
    ack_exp(8'h23, "R8 level line 3");
    rd_chk(3'b000, 8'h08, "R8 level pending survives ack");
    wr(3'b110, 8'h02);
    chk("R8 level re-requests", {7'b0, int_out}, 8'h01);
    irq_in[3] = 0;
    step(2);
    rd_chk(3'b000, 8'h00, "R8 level pending follows input");
    wr(3'b100, 8'h00);
    irq_in[6] = 1;
    step(2);
    ack_exp(8'h26, "R8 edge line 6");
    rd_chk(3'b000, 8'h00, "R8 edge pending cleared");
    wr(3'b110, 8'h02);
    irq_in[6] = 0;

    // R10 rotation
    irq_in[3] = 1; irq_in[5] = 1;
    step(2);
    ack_exp(8'h23, "R10 before rotate");
    wr(3'b110, 8'h04);
    irq_in[3] = 0; step(1);
    irq_in[3] = 1; step(2);
    ack_exp(8'h25, "R10 rotated order picks 5");
    rd_chk(3'b010, 8'h20, "R10 in-service bit 5");
    wr(3'b110, 8'h02);
    rd_chk(3'b010, 8'h00, "R10 eoi under rotation");
    ack_exp(8'h23, "R10 line 3 after 5");
    wr(3'b110, 8'h02);
    irq_in[3] = 0; irq_in[5] = 0;
    step(2);

    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule